// File: doc/BRIEF.md
# Strip Descriptor Display Sequencer

This block lays out the rows of an on-screen display. The screen is not a fixed text grid. It is a chain of strips, and each strip is described by one 16-bit descriptor word in a table in RAM. Each VSYNC pulse restarts the walk at one of sixteen table bases. The sequencer reads descriptors one after another from consecutive addresses. A filler strip produces a run of black or transparent scan lines. A text strip produces a run of active scan lines. On each of those lines the sequencer reads character/attribute words from RAM, beginning at the strip's start address, and passes them downstream. Rendering of the glyphs is done elsewhere.

The RAM port is synchronous with a one-cycle read latency. Fetched words leave on a valid/ready stream. A word stays on `code_data_o` until it is accepted. While `code_valid_o` is high and `code_ready_i` is low, the data is held and no further read is issued, so back-pressure only delays the stream and never drops or repeats a word. A word still pending when VSYNC arrives is discarded. The three line flags are plain level outputs that describe the strip which owns the current scan line.

A strip's first line is the line in progress when its descriptor is decoded. That is the line opened by VSYNC, or the line opened by the HSYNC pulse that closed the previous strip. Each following HSYNC pulse closes one more line.

Top module: `osd_strip_seq`

## Requirements
- R1: From reset until the first VSYNC pulse, no RAM read is issued, `code_valid_o` is low and all three line flags are low.
- R2: In the cycle after a VSYNC pulse, the block reads the address `page_i` × 64 (page number in the top 4 of 10 address bits). This abandons any strip in progress and any pending code word.
- R3: Descriptors are read from consecutive addresses. Bit 15 is 0 for a filler strip, whose bits 7:0 give its line count. Bit 15 is 1 for a text strip, where bit 14 is the enable and bits 9:0 give the start address.
- R4: A filler strip covers its line count in scan lines. `line_black_o` is set when `fill_black_i` was 1 at decode; otherwise `line_transp_o` is set.
- R5: An enabled text strip covers `ch_height_i` scan lines with `line_active_o` set.
- R6: On every line of an enabled text strip, words are fetched upward from the start address and emitted in address order. The first word whose low byte is 8'hFF ends that line's fetch and is not emitted.
- R7: After a `line_end_i` pulse, no further RAM read is issued on that line. A word whose read was still outstanding is dropped.
- R8: A text strip with the enable bit clear still covers `ch_height_i` lines, shows `line_transp_o`, and emits no words.
- R9: A filler strip with count 0, or any text strip while `ch_height_i` is 0, is skipped at once and the next descriptor is read.
- R10: While `code_valid_o` is high and `code_ready_i` is low, `code_data_o` stays stable. Under any ready pattern, the words accepted on a line are exactly those that R6 gives.
- R11: At most one of the three line flags is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vsync_i | input | 1 | One-cycle pulse at the start of a field |
| hsync_i | input | 1 | One-cycle pulse at the start of each scan line |
| line_end_i | input | 1 | One-cycle pulse at the end of the line's fetch window |
| page_i | input | 4 | Descriptor table select, sampled at VSYNC |
| ch_height_i | input | 6 | Lines per text strip, sampled at decode |
| fill_black_i | input | 1 | Filler colour: 1 black, 0 transparent |
| ram_rd_o | output | 1 | RAM read enable |
| ram_addr_o | output | 10 | RAM read address |
| ram_data_i | input | 16 | RAM read data, valid one cycle after the read |
| code_valid_o | output | 1 | Code word available |
| code_ready_i | input | 1 | Downstream accepts the code word |
| code_data_o | output | 16 | Attribute (high byte) and character (low byte) |
| line_black_o | output | 1 | Current line is black filler |
| line_transp_o | output | 1 | Current line is transparent |
| line_active_o | output | 1 | Current line belongs to an enabled text strip |

## Verification
The properties assume that VSYNC, HSYNC and line-end each arrive as single-cycle pulses. They also assume that HSYNC never lands while a descriptor is being read or decoded, and that line-end only falls inside a line, some cycles after that line opens. The stimulus keeps to this by using a fixed 71-cycle line. The sync pulse comes first. Flags are sampled at cycle 30, well after the longest chain of skipped descriptors settles. Line-end comes at cycle 60. Ready is toggled only in the first 45 cycles of a line, so no word is still pending when the next HSYNC arrives.

// File: rtl/osd_seq_pkg.sv
package osd_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DRD,
    S_DDEC,
    S_SPACE,
    S_CFETCH,
    S_CWAIT
  } seq_state_t;

  typedef enum logic [1:0] {
    K_NONE,
    K_BLACK,
    K_TRANSP,
    K_CHAR
  } line_kind_t;

endpackage

// File: rtl/osd_strip_decode.sv
module osd_strip_decode
  import osd_seq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SL_W   = 8,
  parameter int CH_W   = 6,
  localparam int LINE_W = (SL_W > CH_W) ? SL_W : CH_W
) (
  input  logic              is_char_i,
  input  logic              enable_i,
  input  logic [SL_W-1:0]   sl_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [CH_W-1:0]   ch_height_i,
  input  logic              fill_black_i,
  output line_kind_t        kind_o,
  output logic [LINE_W-1:0] lines_o,
  output logic [ADDR_W-1:0] start_o,
  output logic              skip_o
);

  always_comb begin
    if (is_char_i) begin
      lines_o = LINE_W'(ch_height_i);
      kind_o  = enable_i ? K_CHAR : K_TRANSP;
    end else begin
      lines_o = LINE_W'(sl_i);
      kind_o  = fill_black_i ? K_BLACK : K_TRANSP;
    end
    start_o = start_i;
    skip_o  = (lines_o == '0);
  end

endmodule

// File: rtl/osd_line_counter.sv
module osd_line_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         last_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == W'(1));

endmodule

// File: rtl/osd_code_fetch.sv
module osd_code_fetch #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] EOL_CODE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              run_i,
  input  logic              cancel_i,
  input  logic              clear_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              ready_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              eol_o
);

  logic [ADDR_W-1:0] addr_q;
  logic              inflight_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              ret, hit_eol, issue;

  assign ret     = inflight_q && !cancel_i;
  assign hit_eol = ret && (rd_data_i[CODE_W-1:0] == EOL_CODE);
  assign issue   = run_i && !inflight_q && !cancel_i && !line_start_i &&
                   (!valid_q || ready_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      inflight_q <= 1'b0;
      valid_q    <= 1'b0;
      data_q     <= '0;
    end else begin
      if (line_start_i) addr_q <= start_addr_i;
      else if (issue)   addr_q <= addr_q + 1'b1;
      inflight_q <= issue;
      if (clear_i)              valid_q <= 1'b0;
      else if (ret && !hit_eol) valid_q <= 1'b1;
      else if (ready_i)         valid_q <= 1'b0;
      if (ret && !hit_eol) data_q <= rd_data_i;
    end
  end

  assign rd_en_o   = issue;
  assign rd_addr_o = addr_q;
  assign valid_o   = valid_q;
  assign data_o    = data_q;
  assign eol_o     = hit_eol;

endmodule

// File: rtl/osd_strip_seq.sv
module osd_strip_seq
  import osd_seq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int PAGE_W = 4,
  parameter int SL_W   = 8,
  parameter int CH_W   = 6,
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] EOL_CODE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_i,
  input  logic              hsync_i,
  input  logic              line_end_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [CH_W-1:0]   ch_height_i,
  input  logic              fill_black_i,
  output logic              ram_rd_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  input  logic [DATA_W-1:0] ram_data_i,
  output logic              code_valid_o,
  input  logic              code_ready_i,
  output logic [DATA_W-1:0] code_data_o,
  output logic              line_black_o,
  output logic              line_transp_o,
  output logic              line_active_o
);

  localparam int LINE_W     = (SL_W > CH_W) ? SL_W : CH_W;
  localparam int PAGE_SHIFT = ADDR_W - PAGE_W;
  localparam int TYPE_BIT   = DATA_W - 1;
  localparam int EN_BIT     = DATA_W - 2;

  seq_state_t        state_q;
  line_kind_t        kind_q;
  logic [ADDR_W-1:0] desc_addr_q, start_q;
  logic [ADDR_W-1:0] page_base;

  line_kind_t        dec_kind;
  logic [LINE_W-1:0] dec_lines;
  logic [ADDR_W-1:0] dec_start;
  logic              dec_skip;

  logic cnt_load, cnt_dec, cnt_last;
  logic strip_on, text_line, line_start;
  logic fetch_rd, fetch_eol;
  logic [ADDR_W-1:0] fetch_addr;

  assign page_base = {page_i, {PAGE_SHIFT{1'b0}}};

  osd_strip_decode #(.ADDR_W(ADDR_W), .SL_W(SL_W), .CH_W(CH_W)) u_dec (
    .is_char_i    (ram_data_i[TYPE_BIT]),
    .enable_i     (ram_data_i[EN_BIT]),
    .sl_i         (ram_data_i[SL_W-1:0]),
    .start_i      (ram_data_i[ADDR_W-1:0]),
    .ch_height_i  (ch_height_i),
    .fill_black_i (fill_black_i),
    .kind_o       (dec_kind),
    .lines_o      (dec_lines),
    .start_o      (dec_start),
    .skip_o       (dec_skip)
  );

  assign strip_on  = (state_q == S_SPACE) || (state_q == S_CFETCH) ||
                     (state_q == S_CWAIT);
  assign text_line = (state_q == S_CFETCH) || (state_q == S_CWAIT);
  assign cnt_load  = !vsync_i && (state_q == S_DDEC) && !dec_skip;
  assign cnt_dec   = !vsync_i && hsync_i && strip_on && !cnt_last;
  assign line_start = (cnt_load && dec_kind == K_CHAR) ||
                      (!vsync_i && hsync_i && text_line && !cnt_last);

  osd_line_counter #(.W(LINE_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_load),
    .load_val_i (dec_lines),
    .dec_i      (cnt_dec),
    .last_o     (cnt_last)
  );

  osd_code_fetch #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .EOL_CODE(EOL_CODE)
  ) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_start_i (line_start),
    .start_addr_i ((state_q == S_DDEC) ? dec_start : start_q),
    .run_i        (state_q == S_CFETCH),
    .cancel_i     (vsync_i || hsync_i || line_end_i),
    .clear_i      (vsync_i),
    .rd_data_i    (ram_data_i),
    .ready_i      (code_ready_i),
    .rd_en_o      (fetch_rd),
    .rd_addr_o    (fetch_addr),
    .valid_o      (code_valid_o),
    .data_o       (code_data_o),
    .eol_o        (fetch_eol)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      kind_q      <= K_NONE;
      desc_addr_q <= '0;
      start_q     <= '0;
    end else if (vsync_i) begin
      state_q     <= S_DRD;
      kind_q      <= K_NONE;
      desc_addr_q <= page_base;
    end else begin
      case (state_q)
        S_DRD: state_q <= S_DDEC;
        S_DDEC: begin
          if (dec_skip) begin
            desc_addr_q <= desc_addr_q + 1'b1;
            state_q     <= S_DRD;
          end else begin
            kind_q  <= dec_kind;
            start_q <= dec_start;
            state_q <= (dec_kind == K_CHAR) ? S_CFETCH : S_SPACE;
          end
        end
        S_SPACE, S_CFETCH, S_CWAIT: begin
          if (hsync_i && cnt_last) begin
            desc_addr_q <= desc_addr_q + 1'b1;
            kind_q      <= K_NONE;
            state_q     <= S_DRD;
          end else if (hsync_i && text_line) begin
            state_q <= S_CFETCH;
          end else if (state_q == S_CFETCH && (line_end_i || fetch_eol)) begin
            state_q <= S_CWAIT;
          end
        end
        default: ;
      endcase
    end
  end

  assign ram_rd_o      = (state_q == S_DRD) || fetch_rd;
  assign ram_addr_o    = (state_q == S_DRD) ? desc_addr_q : fetch_addr;
  assign line_black_o  = (kind_q == K_BLACK);
  assign line_transp_o = (kind_q == K_TRANSP);
  assign line_active_o = (kind_q == K_CHAR);

endmodule

// File: rtl/osd_strip_seq_chk.sv
module osd_strip_seq_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int PAGE_W = 4,
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] EOL_CODE = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vsync_i,
  input logic              hsync_i,
  input logic              line_end_i,
  input logic [PAGE_W-1:0] page_i,
  input logic              ram_rd_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              code_valid_o,
  input logic              code_ready_i,
  input logic [DATA_W-1:0] code_data_o,
  input logic              line_black_o,
  input logic              line_transp_o,
  input logic              line_active_o
);

  localparam int SHIFT = ADDR_W - PAGE_W;

  // R11
  flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({line_black_o, line_transp_o, line_active_o}));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid_o && !code_ready_i && !vsync_i |=> code_valid_o && $stable(code_data_o));

  // R2
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_i |=> ram_rd_o && (ram_addr_o == (ADDR_W'($past(page_i)) << SHIFT)));

  // R6
  no_eol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid_o |-> code_data_o[CODE_W-1:0] != EOL_CODE);

  // R7
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_end_i && line_active_o && !vsync_i && !hsync_i |=> !ram_rd_o);

endmodule

bind osd_strip_seq osd_strip_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .CODE_W(CODE_W), .EOL_CODE(EOL_CODE)
) u_chk (.*);

// File: tb/sim_osd_strip_seq.sv
module sim_osd_strip_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vsync_i = 1'b0, hsync_i = 1'b0, line_end_i = 1'b0;
  logic [3:0]  page_i = '0;
  logic [5:0]  ch_height_i = '0;
  logic        fill_black_i = 1'b0;
  logic        ram_rd_o;
  logic [9:0]  ram_addr_o;
  logic [15:0] ram_data_i;
  logic        code_valid_o, code_ready_i = 1'b1;
  logic [15:0] code_data_o;
  logic        line_black_o, line_transp_o, line_active_o;

  always #5 clk = ~clk;

  osd_strip_seq u0 (.*);

  logic [15:0] mem [0:1023];
  always @(posedge clk) if (ram_rd_o) ram_data_i <= mem[ram_addr_o];

  int total = 0, bad = 0;
  bit done = 0;

  int          cur_line;
  bit          after_end;
  logic [15:0] got [0:15][0:63];
  int          got_n [0:15];
  int          rd_late [0:15];
  int          exp_kind [0:15];
  int          exp_start [0:15];
  int          obs_flags [0:15];

  always @(negedge clk) begin
    if (code_valid_o && code_ready_i && got_n[cur_line] < 64) begin
      got[cur_line][got_n[cur_line]] = code_data_o;
      got_n[cur_line]++;
    end
    if (after_end && ram_rd_o) rd_late[cur_line]++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic int strlen_at(input int a);
    int n = 0;
    while (n < 200 && mem[(a + n) % 1024][7:0] != 8'hFF) n++;
    return n;
  endfunction

  task automatic put_str(input int a, input int len);
    for (int k = 0; k < len; k++)
      mem[a + k] = {8'(k + 1), 8'((a + k) & 8'h7F)};
    mem[a + len] = 16'h00FF;
  endtask

  // kinds: 1 black, 2 transparent, 3 active text
  task automatic build_expect(input int pg, input int ch, input bit fb, input int nl);
    int a = pg * 64;
    int ln = 0;
    int guard = 0;
    while (ln < nl && guard < 64) begin
      logic [15:0] d = mem[a];
      int n, k, s;
      a++; guard++;
      if (d[15]) begin
        n = ch; k = d[14] ? 3 : 2; s = int'(d[9:0]);
      end else begin
        n = int'(d[7:0]); k = fb ? 1 : 2; s = 0;
      end
      for (int i = 0; i < n && ln < nl; i++) begin
        exp_kind[ln] = k; exp_start[ln] = s; ln++;
      end
    end
  endtask

  task automatic run_frame(input int pg, input int ch, input bit fb, input int nl,
                           input bit bp, input bit trunc);
    page_i = 4'(pg); ch_height_i = 6'(ch); fill_black_i = fb;
    build_expect(pg, ch, fb, nl);
    for (int l = 0; l < 16; l++) begin got_n[l] = 0; rd_late[l] = 0; end
    for (int l = 0; l < nl; l++) begin
      cur_line = l; after_end = 0;
      if (l == 0) vsync_i = 1'b1; else hsync_i = 1'b1;
      tick();
      vsync_i = 1'b0; hsync_i = 1'b0;
      if (l == 0) begin
        // R2: table base read right after VSYNC
        chk(ram_rd_o === 1'b1, "R2 rd", int'(ram_rd_o), 1);
        chk(ram_addr_o == 10'(pg * 64), "R2 addr", int'(ram_addr_o), pg * 64);
      end
      for (int lc = 1; lc < 71; lc++) begin
        code_ready_i = bp ? (lc >= 45 || (lc % 4) >= 2) : 1'b1;
        line_end_i = (lc == 60);
        if (lc == 30) obs_flags[l] = {line_black_o, line_transp_o, line_active_o};
        after_end = (lc > 60);
        tick();
      end
      line_end_i = 1'b0;
    end
    after_end = 0;
    for (int l = 0; l < nl; l++) begin
      int ef = (exp_kind[l] == 1) ? 4 : (exp_kind[l] == 2) ? 2 : 1;
      // R4 R5 R8 R9 R3: line flags per strip
      chk(obs_flags[l] == ef, $sformatf("R4 R5 R8 R9 R3 flags line %0d", l), obs_flags[l], ef);
      // R7
      chk(rd_late[l] == 0, $sformatf("R7 reads after line end line %0d", l), rd_late[l], 0);
      if (exp_kind[l] == 3) begin
        int len = strlen_at(exp_start[l]);
        if (trunc)
          chk(got_n[l] > 0 && got_n[l] <= 32 && got_n[l] < len,
              $sformatf("R7 truncated count line %0d", l), got_n[l], 32);
        else
          chk(got_n[l] == len, $sformatf("R6 R10 count line %0d", l), got_n[l], len);
        for (int k = 0; k < got_n[l] && k < len; k++)
          chk(got[l][k] == mem[exp_start[l] + k], $sformatf("R6 R10 word %0d line %0d", k, l),
              int'(got[l][k]), int'(mem[exp_start[l] + k]));
      end else begin
        // R8: no words on filler or disabled lines
        chk(got_n[l] == 0, $sformatf("R8 R4 no words line %0d", l), got_n[l], 0);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h00FF;
    put_str(700, 3);
    put_str(710, 4);
    put_str(720, 6);
    for (int i = 0; i < 150; i++) mem[800 + i] = {8'h5A, 8'(i & 8'h7F)};
    // page 0
    mem[0] = 16'h0003; mem[1] = 16'hC2BC; mem[2] = 16'h0000;
    mem[3] = 16'h82C6; mem[4] = 16'hC2D0; mem[5] = 16'h0002;
    // page 5
    mem[320] = 16'hC2BC; mem[321] = 16'h0001; mem[322] = 16'h82C6;
    mem[323] = 16'h0000; mem[324] = 16'h0002;
    // page 9 (740 holds an immediate end-of-line)
    mem[576] = 16'hC2D0; mem[577] = 16'h0001; mem[578] = 16'h82C6; mem[579] = 16'hC2E4;
    mem[580] = 16'hC2C6;
    // page 15
    mem[960] = 16'hC320;
    cur_line = 0; after_end = 0;
    for (int l = 0; l < 16; l++) begin got_n[l] = 0; rd_late[l] = 0; end

    repeat (3) tick();
    rst_n = 1'b1;
    repeat (6) tick();
    // R1: idle before first VSYNC
    chk(ram_rd_o === 1'b0, "R1 rd", int'(ram_rd_o), 0);
    chk(code_valid_o === 1'b0, "R1 valid", int'(code_valid_o), 0);
    chk({line_black_o, line_transp_o, line_active_o} === 3'b000, "R1 flags",
        int'({line_black_o, line_transp_o, line_active_o}), 0);

    for (int ch = 1; ch <= 3; ch++)
      for (int fb = 0; fb < 2; fb++)
        run_frame(0, ch, fb[0], 14, 1'b0, 1'b0);
    run_frame(9, 3, 1'b0, 14, 1'b1, 1'b0);   // R10 back-pressure
    run_frame(9, 2, 1'b1, 12, 1'b1, 1'b0);   // R10
    run_frame(5, 0, 1'b1, 6, 1'b0, 1'b0);    // R9 zero height
    run_frame(15, 2, 1'b0, 4, 1'b0, 1'b1);   // R7 truncation

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog all act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule